// File: doc/BRIEF.md
# Byte-Addressed ROM/RAM Memory Subsystem

This block is a small memory subsystem that holds 32-bit words and is reached with byte addresses. The low half of its map is read-only and the next half is read-write. Every address above these two regions returns an error. A single request port carries the address, an access size, a write enable and write data. Exactly one cycle after each request, the block answers with a ready pulse, an error flag and read data.

The two lowest address bits choose the lanes for byte and halfword accesses, numbered little-endian. Sub-word reads come back zero-extended. The read-only region has its own load port, which takes one word per cycle and works only while reset is held. Processor writes to that region are refused with an error. The size of each region is set by `REGION_AW` (the byte-address width of one region). With a value of 16, the read-only region covers 0x000000–0x00FFFF, the read-write region covers 0x010000–0x01FFFF, and everything from 0x020000 upward is an error.

Top module: `memsys_top`

## Requirements
- R1: Addresses below 2^REGION_AW select the read-only region. Addresses from 2^REGION_AW up to 2^(REGION_AW+1)-1 select the read-write region, and the top word of each region is reachable.
- R2: `ready_o` is high in the cycle after each cycle in which `req_i` is high, and low otherwise. Back-to-back requests are each answered.
- R3: A word write (size 2) to the read-write region followed by a word read of the same address returns the written word.
- R4: A byte access (size 0) uses lane `addr_i[1:0]`, where lane k is bits 8k+7:8k. A byte write changes only that lane, and a byte read returns the lane in bits 7:0 with bits 31:8 zero.
- R5: A halfword access (size 1) uses bits 15:0 when `addr_i[1]` is 0 and bits 31:16 when it is 1. A halfword read returns the half in bits 15:0 with bits 31:16 zero.
- R6: A write of any size to the read-only region raises `err_o` with the ready pulse and leaves the stored word unchanged.
- R7: Any access at or above 2^(REGION_AW+1) raises `err_o`. A write there changes no stored word, including the words whose low address bits match.
- R8: A halfword access with `addr_i[0]` set, or a word access with `addr_i[1:0]` nonzero, raises `err_o` and writes nothing.
- R9: Size code 3 is reserved. Any access that uses it raises `err_o` and writes nothing.
- R10: While `rst_ni` is low, each cycle with `init_we_i` high stores `init_data_i` into read-only word `init_addr_i`, which is byte address 4*`init_addr_i`. While `rst_ni` is high, the load port has no effect.
- R11: While `rst_ni` is low, `ready_o`, `err_o` and `rdata_o` are zero, and bus requests have no effect on storage.
- R12: `rdata_o` is zero for every erroring access and for every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid for this cycle |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| we_i | input | 1 | 1 write, 0 read |
| wdata_i | input | 32 | Write data, right-aligned for sub-word sizes |
| rdata_o | output | 32 | Read data, zero-extended |
| ready_o | output | 1 | Completion pulse, one cycle after the request |
| err_o | output | 1 | Error, valid with `ready_o` |
| init_we_i | input | 1 | Read-only load strobe (used in reset only) |
| init_addr_i | input | REGION_AW-2 | Read-only word index for loading |
| init_data_i | input | 32 | Read-only load data |

## Verification
The bench builds the block with REGION_AW=10, which gives a 1 KB read-only region at 0x000–0x3FF and a 1 KB read-write region at 0x400–0x7FF. At that size, every read-only word can be loaded with a computed pattern in 256 cycles during reset. The top word of each region, the first erroring address 0x800, and the address 0xC00 (whose lower index bits match the first read-write word) all fall within a few vectors. The address 0xC00 is the case that exposes a write that aliases instead of being rejected. The default of 12 and the full-map value of 16 change only the decode boundaries and the storage depth.

// File: rtl/memsys_pkg.sv
package memsys_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/memsys_decode.sv
module memsys_decode
  import memsys_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned REGION_AW = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  output logic              in_rom_o,
  output logic              in_ram_o,
  output logic              err_o
);
  localparam int unsigned HI_W = ADDR_W - REGION_AW;

  logic [HI_W-1:0] hi;
  logic            misalign;
  logic            bad_size;

  assign hi       = addr_i[ADDR_W-1:REGION_AW];
  assign in_rom_o = (hi == '0);
  assign in_ram_o = (hi == HI_W'(1));

  always_comb begin
    misalign = 1'b0;
    bad_size = 1'b0;
    unique case (acc_size_e'(size_i))
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = addr_i[0];
      SZ_WORD: misalign = |addr_i[1:0];
      default: bad_size = 1'b1;
    endcase
  end

  assign err_o = ~(in_rom_o | in_ram_o) | misalign | bad_size | (we_i & in_rom_o);
endmodule

// File: rtl/memsys_lanes.sv
module memsys_lanes
  import memsys_pkg::*;
(
  input  logic [1:0]        lo_i,
  input  logic [1:0]        size_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] rword_i,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wword_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] shifted;

  assign shifted = rword_i >> {lo_i, 3'b000};

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin
        be_o    = LANES'(1) << lo_i;
        wword_o = {LANES{wdata_i[7:0]}};
        rdata_o = {{(WORD_W-8){1'b0}}, shifted[7:0]};
      end
      SZ_HALF: begin
        be_o    = lo_i[1] ? 4'b1100 : 4'b0011;
        wword_o = {2{wdata_i[15:0]}};
        rdata_o = {{(WORD_W-16){1'b0}}, shifted[15:0]};
      end
      default: begin
        be_o    = '1;
        wword_o = wdata_i;
        rdata_o = rword_i;
      end
    endcase
  end
endmodule

// File: rtl/memsys_store.sv
module memsys_store
  import memsys_pkg::*;
#(
  parameter int unsigned REGION_AW = 12
) (
  input  logic                   clk_i,
  input  logic                   bus_we_i,
  input  logic [REGION_AW-2:0]   bus_idx_i,
  input  logic [LANES-1:0]       bus_be_i,
  input  logic [WORD_W-1:0]      bus_wdata_i,
  output logic [WORD_W-1:0]      rd_word_o,
  input  logic                   init_we_i,
  input  logic [REGION_AW-3:0]   init_idx_i,
  input  logic [WORD_W-1:0]      init_data_i
);
  localparam int unsigned IDX_W = REGION_AW - 1;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] init_full;
  assign init_full = {1'b0, init_idx_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (init_we_i) begin
        lane_q[init_full] <= init_data_i[8*g +: 8];
      end else if (bus_we_i && bus_be_i[g]) begin
        lane_q[bus_idx_i] <= bus_wdata_i[8*g +: 8];
      end
    end

    assign rd_word_o[8*g +: 8] = lane_q[bus_idx_i];
  end
endmodule

// File: rtl/memsys_top.sv
module memsys_top
  import memsys_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned REGION_AW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic                 we_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 ready_o,
  output logic                 err_o,
  input  logic                 init_we_i,
  input  logic [REGION_AW-3:0] init_addr_i,
  input  logic [31:0]          init_data_i
);
  logic              in_rom, in_ram, dec_err;
  logic [LANES-1:0]  be;
  logic [WORD_W-1:0] wword, rword, rext;
  logic              bus_we, init_we;
  logic              ready_q, err_q;
  logic [WORD_W-1:0] rdata_q;

  memsys_decode #(.ADDR_W(ADDR_W), .REGION_AW(REGION_AW)) dec_i (
    .addr_i   (addr_i),
    .size_i   (size_i),
    .we_i     (we_i),
    .in_rom_o (in_rom),
    .in_ram_o (in_ram),
    .err_o    (dec_err)
  );

  memsys_lanes lanes_i (
    .lo_i    (addr_i[1:0]),
    .size_i  (size_i),
    .wdata_i (wdata_i),
    .rword_i (rword),
    .be_o    (be),
    .wword_o (wword),
    .rdata_o (rext)
  );

  // bus writes land only in RAM and only out of reset; loading only in reset
  assign bus_we  = rst_ni & req_i & we_i & in_ram & ~dec_err;
  assign init_we = ~rst_ni & init_we_i;

  memsys_store #(.REGION_AW(REGION_AW)) store_i (
    .clk_i       (clk_i),
    .bus_we_i    (bus_we),
    .bus_idx_i   (addr_i[REGION_AW:2]),
    .bus_be_i    (be),
    .bus_wdata_i (wword),
    .rd_word_o   (rword),
    .init_we_i   (init_we),
    .init_idx_i  (init_addr_i),
    .init_data_i (init_data_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= req_i;
      err_q   <= req_i & dec_err;
      rdata_q <= (req_i && !we_i && !dec_err) ? rext : '0;
    end
  end

  assign ready_o = ready_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/memsys_chk.sv
module memsys_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned REGION_AW = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              we_i,
  input logic [31:0]       rdata_o,
  input logic              ready_o,
  input logic              err_o
);
  // R2
  ready_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);
  // R2
  no_spurious_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);
  // R12
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && rdata_o == '0));
  // R12
  write_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> rdata_o == '0);
  // R6
  rom_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i >> REGION_AW) == '0) |=> err_o);
  // R7
  range_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (addr_i >> (REGION_AW + 1)) != '0) |=> err_o);
  // R8
  misalign_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ((size_i == 2'd1 && addr_i[0]) || (size_i == 2'd2 && addr_i[1:0] != 2'b00)))
    |=> err_o);
  // R9
  rsvd_size_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd3) |=> err_o);
  // R4
  byte_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd0) |=> rdata_o[31:8] == '0);
  // R5
  half_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd1) |=> rdata_o[31:16] == '0);
endmodule

bind memsys_top memsys_chk #(.ADDR_W(ADDR_W), .REGION_AW(REGION_AW)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .addr_i  (addr_i),
  .size_i  (size_i),
  .we_i    (we_i),
  .rdata_o (rdata_o),
  .ready_o (ready_o),
  .err_o   (err_o)
);

// File: tb/memsys_top_tb_top.sv
module memsys_top_tb_top;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned REGION_AW = 10;
  localparam int unsigned ROM_WORDS = 1 << (REGION_AW - 2);

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        err;
    logic [31:0] rd;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 32'h004, 32'h0,        1'b0, 32'h80010003, 4'd3},  // R3 rom word
    '{1'b0, 2'd0, 32'h007, 32'h0,        1'b0, 32'h00000080, 4'd4},  // R4 lane 3
    '{1'b0, 2'd0, 32'h004, 32'h0,        1'b0, 32'h00000003, 4'd4},  // R4 lane 0
    '{1'b0, 2'd1, 32'h006, 32'h0,        1'b0, 32'h00008001, 4'd5},  // R5 upper half
    '{1'b0, 2'd1, 32'h004, 32'h0,        1'b0, 32'h00000003, 4'd5},  // R5 lower half
    '{1'b1, 2'd2, 32'h400, 32'h11223344, 1'b0, 32'h0,        4'd3},  // R3 write
    '{1'b0, 2'd2, 32'h400, 32'h0,        1'b0, 32'h11223344, 4'd3},  // R3 read back
    '{1'b1, 2'd0, 32'h401, 32'h000000AB, 1'b0, 32'h0,        4'd4},  // R4 byte write
    '{1'b0, 2'd2, 32'h400, 32'h0,        1'b0, 32'h1122AB44, 4'd4},
    '{1'b1, 2'd1, 32'h402, 32'h0000BEEF, 1'b0, 32'h0,        4'd5},  // R5 half write
    '{1'b0, 2'd2, 32'h400, 32'h0,        1'b0, 32'hBEEFAB44, 4'd5},
    '{1'b0, 2'd0, 32'h403, 32'h0,        1'b0, 32'h000000BE, 4'd4},
    '{1'b1, 2'd2, 32'h008, 32'hFFFFFFFF, 1'b1, 32'h0,        4'd6},  // R6 rom write
    '{1'b0, 2'd2, 32'h008, 32'h0,        1'b0, 32'h80020006, 4'd6},
    '{1'b1, 2'd0, 32'h004, 32'h000000FF, 1'b1, 32'h0,        4'd6},
    '{1'b0, 2'd2, 32'h004, 32'h0,        1'b0, 32'h80010003, 4'd6},
    '{1'b0, 2'd2, 32'h800, 32'h0,        1'b1, 32'h0,        4'd7},  // R7 first bad addr
    '{1'b1, 2'd2, 32'hC00, 32'hDEADBEEF, 1'b1, 32'h0,        4'd7},  // R7 alias of 0x400
    '{1'b0, 2'd2, 32'h400, 32'h0,        1'b0, 32'hBEEFAB44, 4'd7},
    '{1'b0, 2'd2, 32'hFFFFFFFC, 32'h0,   1'b1, 32'h0,        4'd7},
    '{1'b0, 2'd1, 32'h401, 32'h0,        1'b1, 32'h0,        4'd8},  // R8 odd half
    '{1'b1, 2'd2, 32'h402, 32'h0,        1'b1, 32'h0,        4'd8},  // R8 unaligned word
    '{1'b0, 2'd2, 32'h400, 32'h0,        1'b0, 32'hBEEFAB44, 4'd8},
    '{1'b0, 2'd3, 32'h400, 32'h0,        1'b1, 32'h0,        4'd9},  // R9 reserved size
    '{1'b1, 2'd3, 32'h400, 32'h0,        1'b1, 32'h0,        4'd9},
    '{1'b0, 2'd2, 32'h400, 32'h0,        1'b0, 32'hBEEFAB44, 4'd9},
    '{1'b1, 2'd2, 32'h7FC, 32'hCAFEF00D, 1'b0, 32'h0,        4'd1},  // R1 top of RAM
    '{1'b0, 2'd2, 32'h7FC, 32'h0,        1'b0, 32'hCAFEF00D, 4'd1},
    '{1'b0, 2'd2, 32'h3FC, 32'h0,        1'b0, 32'h80FF02FD, 4'd1},  // R1 top of ROM
    '{1'b0, 2'd0, 32'h3FF, 32'h0,        1'b0, 32'h00000080, 4'd1}
  };

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 req_i = 1'b0;
  logic [ADDR_W-1:0]    addr_i = '0;
  logic [1:0]           size_i = '0;
  logic                 we_i = 1'b0;
  logic [31:0]          wdata_i = '0;
  logic [31:0]          rdata_o;
  logic                 ready_o;
  logic                 err_o;
  logic                 init_we_i = 1'b0;
  logic [REGION_AW-3:0] init_addr_i = '0;
  logic [31:0]          init_data_i = '0;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  memsys_top #(.ADDR_W(ADDR_W), .REGION_AW(REGION_AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .size_i(size_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ready_o(ready_o), .err_o(err_o), .init_we_i(init_we_i),
    .init_addr_i(init_addr_i), .init_data_i(init_data_i)
  );

  function automatic logic [31:0] rom_pat(int i);
    return 32'h8000_0000 | (32'(i) * 32'h0001_0003);
  endfunction

  task automatic chk(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic we, logic [1:0] sz, logic [31:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = we; size_i = sz; addr_i = a; wdata_i = d;
  endtask

  // one request, then check {ready, err, rdata} at the following negedge
  task automatic access(string tag, logic we, logic [1:0] sz, logic [31:0] a,
                        logic [31:0] d, logic e, logic [31:0] r);
    @(negedge clk_i);
    drive(we, sz, a, d);
    @(negedge clk_i);
    req_i = 1'b0;
    chk(tag, {ready_o, err_o, rdata_o}, {1'b1, e, r});
  endtask

  initial begin
    // R10 load all ROM words during reset; R11 outputs quiet in reset
    for (int i = 0; i < ROM_WORDS; i++) begin
      @(negedge clk_i);
      init_we_i = 1'b1; init_addr_i = (REGION_AW-2)'(i); init_data_i = rom_pat(i);
    end
    @(negedge clk_i);
    init_we_i = 1'b0;
    chk("R11 reset outputs", {ready_o, err_o, rdata_o}, 34'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 idle no ready", {ready_o, err_o, rdata_o}, 34'h0);

    for (int v = 0; v < NV; v++) begin
      access($sformatf("R%0d vec %0d", VECS[v].tag, v), VECS[v].we, VECS[v].sz,
             VECS[v].addr, VECS[v].wd, VECS[v].err, VECS[v].rd);
    end

    // R2 back-to-back requests, then idle
    @(negedge clk_i);
    drive(1'b0, 2'd2, 32'h004, 32'h0);
    @(negedge clk_i);
    chk("R2 b2b first", {ready_o, err_o, rdata_o}, {2'b10, 32'h80010003});
    drive(1'b0, 2'd2, 32'h008, 32'h0);
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R2 b2b second", {ready_o, err_o, rdata_o}, {2'b10, 32'h80020006});
    @(negedge clk_i);
    chk("R2 idle after", {33'h0, ready_o}, 34'h0);

    // R10 load port ignored out of reset
    init_we_i = 1'b1; init_addr_i = 'd1; init_data_i = 32'h0;
    @(negedge clk_i);
    init_we_i = 1'b0;
    access("R10 load ignored", 1'b0, 2'd2, 32'h004, 32'h0, 1'b0, 32'h80010003);

    // R11 bus write during reset has no effect
    access("R11 pre-write", 1'b1, 2'd2, 32'h404, 32'h12345678, 1'b0, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    drive(1'b1, 2'd2, 32'h404, 32'h00000055);
    @(negedge clk_i);
    chk("R11 no ready in reset", {ready_o, err_o, rdata_o}, 34'h0);
    req_i = 1'b0;
    rst_ni = 1'b1;
    access("R11 storage kept", 1'b0, 2'd2, 32'h404, 32'h0, 1'b0, 32'h12345678);
    access("R10 rom kept", 1'b0, 2'd2, 32'h3FC, 32'h0, 1'b0, rom_pat(255));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule